// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a three-wire serial EEPROM. A host drives chip select, a serial clock and a data line. The block returns data on one output line. Behind the serial port sits an array of 64 words, each 16 bits wide. Every host transaction begins with a start bit, followed by an eight-bit field: two command bits, then a six-bit word address. The command field selects one of the following:

- read
- write
- erase one word
- write every word
- erase every word
- set or clear a write-enable latch

All serial inputs are oversampled by a fast system clock. Each input passes through a synchroniser, and the block reacts to the serial clock's rising edges as the system clock observes them. Programming takes no time: a modifying command updates the array in the same system cycle that it completes. The array comes out of reset holding all ones, with writes locked.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the data output is high, the write-enable latch is clear, the block is idle, and every word reads back as 0xFFFF.
- R2: Serial clock rising edges that arrive while chip select is low change nothing, so the array and the next command are unaffected.
- R3: While idle, rising edges with data-in low are skipped. The first rising edge with data-in high is taken as the start bit and begins capture of the eight-bit command field.
- R4: The command field is shifted in MSB first. Bits 7:6 hold the command code (10 read, 01 write, 11 erase, 00 special). Bits 5:0 hold the word address.
- R5: When a read is decoded, the data output drops to a 0 dummy bit. On each later rising edge it presents the next bit of the addressed word, MSB first.
- R6: Once all 16 bits of a word have been sent, the read continues with the next address, modulo 64, with no gap, for as long as chip select stays high.
- R7: A write takes 16 data bits MSB first. On the 16th bit it stores them to the addressed word, provided the write-enable latch is set.
- R8: An erase sets the addressed word to 0xFFFF at the moment the command field completes, provided the latch is set.
- R9: For a special command, bits 5:4 select the action. The value 01 takes 16 data bits and stores them into all 64 words. The value 10 sets all 64 words to 0xFFFF. Both act only with the latch set.
- R10: A special command with bits 5:4 equal to 11 sets the write-enable latch, and one with 00 clears it. While the latch is clear, write, erase, write-all and erase-all leave the array unchanged.
- R11: After a write, erase, write-all, erase-all or latch command completes, every further clock edge is ignored until chip select falls.
- R12: A falling edge on chip select returns the block to idle and drives the data output high, even in the middle of a read.
- R13: The data output changes exactly three system clock cycles after the serial clock or chip select change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| sdo_o | output | 1 | Serial data out, registered |

## Verification
A serial input change needs two synchroniser stages to reach the edge detector, and the output register adds one more cycle. Every output effect is therefore due on the third system clock after the stimulus is driven. The bench's behavioural reference runs on the raw input levels, and its predicted output is delayed by that amount before it is compared, once per system clock. Explicit word reads sample the output at the end of each serial clock high phase, four system clocks after the rise, so the sampled bit has already settled. A dedicated check probes the dummy bit one cycle before and on the cycle it is due.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  // Controller states
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPCODE = 3'd1,
    ST_WDATA  = 3'd2,
    ST_RDATA  = 3'd3,
    ST_HOLD   = 3'd4
  } tw_state_e;

  // Two-bit command codes carried in the top of the command field
  localparam logic [1:0] CMD_SPECIAL = 2'b00;
  localparam logic [1:0] CMD_WRITE   = 2'b01;
  localparam logic [1:0] CMD_READ    = 2'b10;
  localparam logic [1:0] CMD_ERASE   = 2'b11;

  // Sub-codes of a special command (top two address bits)
  localparam logic [1:0] SUB_WRALL   = 2'b01;
  localparam logic [1:0] SUB_ERALL   = 2'b10;

endpackage

// File: rtl/tw_input_sync.sv
module tw_input_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_q
);

  // One independent flop chain per input bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/tw_edge_detect.sv
module tw_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  output logic sck_rise,
  output logic cs_fall
);

  logic cs_prev;
  logic sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev  <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_prev;
  assign cs_fall  = cs_prev & ~cs_s;

endmodule

// File: rtl/tw_word_array.sv
module tw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Flop array: a single-cycle fill of every word rules out block RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_all || (wr_one && (wr_addr == ADDR_W'(i)))) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tw_cmd_fsm.sv
module tw_cmd_fsm
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_on,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_one,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output tw_state_e         state_o,
  output logic              wen_o
);

  localparam int OPC_W   = ADDR_W + 2;
  localparam int CNT_MAX = (DATA_W > OPC_W) ? DATA_W : OPC_W;
  localparam int CNT_W   = $clog2(CNT_MAX);

  tw_state_e         state_q, state_n;
  logic [OPC_W-1:0]  opc_q, opc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] shr_q, shr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              sdo_q, sdo_n;
  logic              wen_q, wen_n;

  logic [OPC_W-1:0]  opc_shift;
  logic [DATA_W-1:0] dat_shift;
  logic [1:0]        cmd;
  logic [1:0]        sub;
  logic [CNT_W-1:0]  bit_sel;

  assign opc_shift = {opc_q[OPC_W-2:0], sdi};
  assign dat_shift = {shr_q[DATA_W-2:0], sdi};
  assign cmd       = opc_shift[OPC_W-1 -: 2];
  assign sub       = opc_shift[ADDR_W-1 -: 2];
  assign bit_sel   = CNT_W'(DATA_W - 1) - cnt_q;

  always_comb begin
    state_n = state_q;
    opc_n   = opc_q;
    cnt_n   = cnt_q;
    shr_n   = shr_q;
    addr_n  = addr_q;
    sdo_n   = sdo_q;
    wen_n   = wen_q;
    wr_one  = 1'b0;
    wr_all  = 1'b0;
    wr_addr = opc_q[ADDR_W-1:0];
    wr_data = shr_q;

    if (cs_fall) begin
      state_n = ST_IDLE;
      sdo_n   = 1'b1;
    end else if (cs_on && sck_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          if (sdi) begin
            state_n = ST_OPCODE;
            opc_n   = '0;
            cnt_n   = '0;
          end
        end

        ST_OPCODE: begin
          opc_n = opc_shift;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(OPC_W - 1)) begin
            cnt_n = '0;
            unique case (cmd)
              CMD_WRITE: begin
                state_n = ST_WDATA;
                shr_n   = '0;
              end
              CMD_READ: begin
                state_n = ST_RDATA;
                addr_n  = opc_shift[ADDR_W-1:0];
                sdo_n   = 1'b0;
              end
              CMD_ERASE: begin
                wr_one  = wen_q;
                wr_addr = opc_shift[ADDR_W-1:0];
                wr_data = '1;
                state_n = ST_HOLD;
              end
              default: begin
                if (sub == SUB_WRALL) begin
                  state_n = ST_WDATA;
                  shr_n   = '0;
                end else if (sub == SUB_ERALL) begin
                  wr_all  = wen_q;
                  wr_data = '1;
                  state_n = ST_HOLD;
                end else begin
                  wen_n   = sub[0];
                  state_n = ST_HOLD;
                end
              end
            endcase
          end
        end

        ST_WDATA: begin
          shr_n = dat_shift;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            wr_data = dat_shift;
            if (opc_q[OPC_W-2]) wr_one = wen_q;
            else                wr_all = wen_q;
            state_n = ST_HOLD;
          end
        end

        ST_RDATA: begin
          sdo_n = rd_data[bit_sel];
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_n  = '0;
            addr_n = addr_q + ADDR_W'(1);
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      cnt_q   <= '0;
      shr_q   <= '0;
      addr_q  <= '0;
      sdo_q   <= 1'b1;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      opc_q   <= opc_n;
      cnt_q   <= cnt_n;
      shr_q   <= shr_n;
      addr_q  <= addr_n;
      sdo_q   <= sdo_n;
      wen_q   <= wen_n;
    end
  end

  assign rd_addr = addr_q;
  assign sdo     = sdo_q;
  assign state_o = state_q;
  assign wen_o   = wen_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);

  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s;
  logic              sck_rise, cs_fall;
  logic              wr_one, wr_all;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  tw_state_e         fsm_state;
  logic              wen_state;

  tw_input_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({cs_i, sck_i, sdi_i}),
    .sync_q   (pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  tw_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .sck_rise (sck_rise),
    .cs_fall  (cs_fall)
  );

  tw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sck_rise (sck_rise),
    .cs_fall  (cs_fall),
    .cs_on    (cs_s),
    .sdi      (sdi_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_one   (wr_one),
    .wr_all   (wr_all),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdo_o),
    .state_o  (fsm_state),
    .wen_o    (wen_state)
  );

  tw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .wr_one  (wr_one),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/tw_eeprom_checks.sv
module tw_eeprom_checks
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sdo,
  input logic              sck_rise,
  input logic              cs_fall,
  input tw_state_e         state,
  input logic              wen,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);

  // R1: reset leaves the block idle, output high, writes locked
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && sdo && !wen));

  // R2: with no serial edge and no deselect, nothing moves
  p_quiet_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    (!sck_rise && !cs_fall) |=> ($stable(state) && $stable(sdo) && $stable(wen)));

  // R5: entering the read phase puts the dummy zero on the output
  p_read_dummy_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && $past(state) == ST_OPCODE) |-> !sdo);

  // R10: the latch only moves when a command field completes
  p_latch_source_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(wen) |-> ($past(state) == ST_OPCODE));

  // R10: with writes locked the addressed word cannot change
  p_locked_array_r10: assert property (@(posedge clk) disable iff (rst)
    !wen |=> (!$stable(rd_addr) || $stable(rd_data)));

  // R11: a completed non-read command stays parked until deselect
  p_hold_parked_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !cs_fall) |=> (state == ST_HOLD));

  // R12: deselect returns to idle with the output high
  p_deselect_idle_r12: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (state == ST_IDLE && sdo));

  // R12: the output is high whenever the block is idle
  p_idle_high_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sdo);

endmodule

bind tw_eeprom_slave tw_eeprom_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .sdo      (sdo_o),
  .sck_rise (sck_rise),
  .cs_fall  (cs_fall),
  .state    (fsm_state),
  .wen      (wen_state),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/tw_eeprom_slave_tb_top.sv
module tw_eeprom_slave_tb_top;

  localparam int H   = 4;   // system clocks per serial half period
  localparam int LAT = 3;   // system clocks from input change to output

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs  = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;   // 125 MHz

  tw_eeprom_slave dut_i (
    .clk   (clk),
    .rst   (rst),
    .cs_i  (cs),
    .sck_i (sck),
    .sdi_i (sdi),
    .sdo_o (sdo)
  );

  // ---------------- behavioural reference ----------------
  int m_state;   // 0 idle, 1 field, 2 data in, 3 data out, 4 parked
  int m_cnt, m_opc, m_buf, m_addr;
  bit m_wen, m_sdo, m_pcs, m_psck;
  int m_mem [64];
  bit pipe [LAT-1];

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_opc = 0; m_buf = 0; m_addr = 0;
    m_wen = 0; m_sdo = 1; m_pcs = 0; m_psck = 0;
    for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
    for (int i = 0; i < LAT-1; i++) pipe[i] = 1'b1;
  endtask

  task automatic model_step(input bit c, input bit k, input bit d);
    if (!c) begin
      if (m_pcs) begin m_state = 0; m_sdo = 1; end
    end else if (k && !m_psck) begin
      case (m_state)
        0: if (d) begin m_state = 1; m_opc = 0; m_cnt = 0; end
        1: begin
          m_opc = ((m_opc << 1) | d) & 255;
          m_cnt++;
          if (m_cnt == 8) begin
            m_cnt = 0;
            case (m_opc >> 6)
              1: begin m_state = 2; m_buf = 0; end
              2: begin m_state = 3; m_addr = m_opc & 63; m_sdo = 0; end
              3: begin if (m_wen) m_mem[m_opc & 63] = 16'hFFFF; m_state = 4; end
              default: begin
                case ((m_opc >> 4) & 3)
                  1: begin m_state = 2; m_buf = 0; end
                  2: begin
                    if (m_wen) for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
                    m_state = 4;
                  end
                  default: begin m_wen = ((m_opc >> 4) & 1) != 0; m_state = 4; end
                endcase
              end
            endcase
          end
        end
        2: begin
          m_buf = ((m_buf << 1) | d) & 16'hFFFF;
          m_cnt++;
          if (m_cnt == 16) begin
            if (m_wen) begin
              if ((m_opc & 64) != 0) m_mem[m_opc & 63] = m_buf;
              else for (int i = 0; i < 64; i++) m_mem[i] = m_buf;
            end
            m_state = 4;
          end
        end
        3: begin
          m_sdo = ((m_mem[m_addr] >> (15 - m_cnt)) & 1) != 0;
          m_cnt++;
          if (m_cnt == 16) begin m_cnt = 0; m_addr = (m_addr + 1) % 64; end
        end
        default: ;
      endcase
    end
    m_pcs = c;
    m_psck = k;
  endtask

  // Inputs are read here before the drivers' updates of this edge land.
  always @(negedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      model_step(cs, sck, sdi);
      checks++;
      if (sdo !== pipe[LAT-2]) begin
        errors++;
        $display("FAIL %s/R13 per-cycle sdo at %0t: actual %0b expected %0b",
                 cur_req, $time, sdo, pipe[LAT-2]);
      end
      for (int i = LAT-2; i > 0; i--) pipe[i] = pipe[i-1];
      pipe[0] = m_sdo;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input bit b, output bit s);
    @(negedge clk); sdi <= b;
    repeat (H - 1) @(negedge clk);
    @(negedge clk); sck <= 1'b1;
    repeat (H) @(negedge clk);
    s = sdo;
    sck <= 1'b0;
  endtask

  task automatic bit_out(input bit b);
    bit s;
    bit_io(b, s);
  endtask

  task automatic cs_up();
    @(negedge clk); cs <= 1'b1; sck <= 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs <= 1'b0; sdi <= 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic send_field(input bit [1:0] c, input bit [5:0] f, output bit last);
    bit [7:0] w;
    w = {c, f};
    bit_out(1'b1);
    for (int i = 7; i >= 0; i--) bit_io(w[i], last);
  endtask

  task automatic send_data(input bit [15:0] v);
    for (int i = 15; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic get_word(output int v);
    bit s;
    v = 0;
    for (int i = 0; i < 16; i++) begin
      bit_io(1'b0, s);
      v = (v << 1) | int'(s);
    end
  endtask

  task automatic cmd_only(input bit [1:0] c, input bit [5:0] f);
    bit s;
    cs_up(); send_field(c, f, s); cs_down();
  endtask

  task automatic write_word(input bit [5:0] a, input bit [15:0] v);
    bit s;
    cs_up(); send_field(2'b01, a, s); send_data(v); cs_down();
  endtask

  task automatic read_one(input string tag, input bit [5:0] a, input int exp);
    bit d; int v;
    cs_up(); send_field(2'b10, a, d);
    chk({tag, " dummy bit"}, int'(d), 0);
    get_word(v);
    chk(tag, v, exp);
    cs_down();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    bit s;
    int v;
    repeat (5) @(negedge clk);
    rst <= 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    chk("R1 sdo high after reset", int'(sdo), 1);
    read_one("R1 R4 erased word at 5", 6'd5, 16'hFFFF);

    cur_req = "R10";
    write_word(6'd3, 16'h1234);
    read_one("R10 locked write ignored", 6'd3, 16'hFFFF);
    cmd_only(2'b00, 6'b110000);          // latch set

    cur_req = "R7";
    write_word(6'd3, 16'hA5C3);
    read_one("R7 R4 word 3", 6'd3, 16'hA5C3);
    write_word(6'd63, 16'h1357);
    write_word(6'd0, 16'h2468);

    cur_req = "R6";
    cs_up(); send_field(2'b10, 6'd63, s);
    chk("R5 dummy before word 63", int'(s), 0);
    get_word(v); chk("R6 word 63", v, 16'h1357);
    get_word(v); chk("R6 wrap to word 0", v, 16'h2468);
    get_word(v); chk("R6 word 1", v, 16'hFFFF);
    cs_down();

    cur_req = "R11";
    cs_up(); send_field(2'b01, 6'd3, s); send_data(16'h0F00);
    send_field(2'b01, 6'd3, s); send_data(16'h0000);   // must be ignored
    cs_down();
    read_one("R11 parked after write", 6'd3, 16'h0F00);

    cur_req = "R8";
    cmd_only(2'b11, 6'd3);
    read_one("R8 erase word 3", 6'd3, 16'hFFFF);

    cur_req = "R2";
    bit_out(1'b1);                       // cs low the whole time
    for (int i = 0; i < 8; i++) bit_out(i == 1);
    send_data(16'h0000);
    cs_up(); send_data(16'h0000); cs_down();
    read_one("R2 deselected clocks ignored", 6'd0, 16'h2468);

    cur_req = "R3";
    cs_up();
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    send_field(2'b10, 6'd63, s);
    chk("R3 dummy after leading zeros", int'(s), 0);
    get_word(v); chk("R3 word after leading zeros", v, 16'h1357);
    cs_down();

    cur_req = "R12";
    cs_up(); send_field(2'b10, 6'd63, s);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    cs_down();
    chk("R12 sdo high after deselect", int'(sdo), 1);
    read_one("R12 fresh read after abort", 6'd0, 16'h2468);

    cur_req = "R13";
    cs_up();
    bit_out(1'b1);
    for (int i = 0; i < 7; i++) bit_out(i == 0);    // 1000000 then last bit
    @(negedge clk); sdi <= 1'b0;
    repeat (H - 1) @(negedge clk);
    @(negedge clk); sck <= 1'b1;
    repeat (LAT - 1) @(negedge clk);
    chk("R13 output not yet changed", int'(sdo), 1);
    @(negedge clk);
    chk("R13 dummy on third cycle", int'(sdo), 0);
    repeat (H - LAT) @(negedge clk);
    sck <= 1'b0;
    get_word(v); chk("R13 word 0 after timed field", v, 16'h2468);
    cs_down();

    cur_req = "R9";
    cs_up(); send_field(2'b00, 6'b010000, s); send_data(16'h0F0F); cs_down();
    read_one("R9 write-all word 10", 6'd10, 16'h0F0F);
    read_one("R9 write-all word 40", 6'd40, 16'h0F0F);
    cmd_only(2'b00, 6'b100000);
    read_one("R9 erase-all word 7", 6'd7, 16'hFFFF);

    cur_req = "R10";
    cmd_only(2'b00, 6'b000000);          // latch clear
    write_word(6'd1, 16'hBEEF);
    read_one("R10 write after lock", 6'd1, 16'hFFFF);
    cmd_only(2'b00, 6'b110000);
    write_word(6'd9, 16'h5A5A);
    cmd_only(2'b00, 6'b000000);
    cmd_only(2'b11, 6'd9);
    cmd_only(2'b00, 6'b100000);
    read_one("R10 erase and erase-all locked", 6'd9, 16'h5A5A);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule